// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a free-running up-counter peripheral. Software reaches it through a word-addressed register bus. It picks one of three tick sources, each of which arrives as a single-cycle enable strobe in the system clock domain: a peripheral-clock strobe, a slow 32 kHz reference strobe, or a high-frequency oscillator strobe. It divides the chosen source through a main prescaler and counts qualifying ticks into a counter that software can read back.

The oscillator source passes through an extra small divider before it reaches the main prescaler. An enable bit in the control register gates the oscillator input. A self-clearing software reset puts the whole block back to its power-on state without asserting the hardware reset.

Top module: `tick_timer`

## Requirements
- R1: After hardware reset, the control word (word 0), the prescaler word (word 1), the status word (word 2) and the counter word (word 9) all read 0.
- R2: Word 0 holds control bits 0, 6 to 10 and 15, and all its other bits read 0. Word 1 holds prescaler bits 15:0, and bits 31:16 read 0. Word 2 always reads 0, and so does every word address other than 0, 1, 2 and 9.
- R3: The counter advances only while control bit 0 is 1. Clearing bit 0 freezes the count at its value. Setting bit 0 again resumes counting from that value.
- R4: Control bits 8:6 choose the tick source: 3'b001 selects the peripheral strobe, 3'b100 the reference strobe and 3'b101 the oscillator strobe. Any other code produces no counts, and strobes of an unselected source have no effect.
- R5: When source 3'b101 is selected and control bit 10 is 0, oscillator strobes produce no counts.
- R6: Prescaler bits 11:0 hold a value N. For every source, the counter advances once per N+1 qualifying ticks.
- R7: Prescaler bits 15:12 hold a value M. On the oscillator source only, strobes are first divided by M+1 and then by N+1. For example, M=7 and N=0 give one count per 8 strobes.
- R8: The counter wraps from all ones (0xFFFFFFFF at default width) to 0. This happens whether control bit 9 is 0 or 1.
- R9: Writes to word 9 never change the counter. A tick in the same cycle still advances it.
- R10: A write to word 0 with bit 15 set does not update the control fields. In the next cycle, the control word, the prescaler word, the counter and both divider counts are cleared, and any tick in that cycle is lost. Bit 15 always reads 0.
- R11: A strobe that completes a division is seen by the counter at the clock edge that samples it. The new value is readable in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Word address for reads and writes |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| perTick | input | 1 | Peripheral-clock tick strobe |
| refTick | input | 1 | 32 kHz reference tick strobe |
| oscTick | input | 1 | Oscillator tick strobe |

## Verification
Two functions can fall in the same cycle. First, a software-reset clear cycle can coincide with a tick that would complete a division. The bench provokes this by holding the peripheral strobe high through the reset write and the following clear cycle, with division by one. It then expects the tick in the write cycle to count, the tick in the clear cycle to be lost, and the counter and registers to read zero. Second, a counter-word write can coincide with a tick, and the bench judges this by the counter advancing by exactly one.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Word addresses on the register bus
  localparam int CTRL_WORD = 0;
  localparam int PRE_WORD  = 1;
  localparam int STAT_WORD = 2;
  localparam int CNT_WORD  = 9;

  // Control word field positions
  localparam int EN_BIT     = 0;
  localparam int SRC_LSB    = 6;
  localparam int MODE_BIT   = 9;
  localparam int OSC_EN_BIT = 10;
  localparam int SWR_BIT    = 15;

  // Prescaler word: oscillator divider field position
  localparam int OSC_DIV_LSB = 12;

  // Source selector codes
  localparam logic [2:0] SRC_PER = 3'b001;
  localparam logic [2:0] SRC_REF = 3'b100;
  localparam logic [2:0] SRC_OSC = 3'b101;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;   // one qualifying source tick
    logic clear;  // software-reset clear cycle
  } tmrStrobe_t;

endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int MAIN_DIV_W = 12,
  parameter int OSC_DIV_W  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wrData,
  input  logic                  perTick,
  input  logic                  refTick,
  input  logic                  oscTick,
  output tmrStrobe_t            strobe,
  output logic [MAIN_DIV_W-1:0] mainDiv,
  output logic [31:0]           ctrlWord,
  output logic [31:0]           preWord
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_WORD);
  localparam logic [ADDR_W-1:0] PRE_A  = ADDR_W'(PRE_WORD);

  logic                 enQ, modeQ, oscEnQ, clearQ;
  logic [2:0]           srcQ;
  logic [MAIN_DIV_W-1:0] mainDivQ;
  logic [OSC_DIV_W-1:0]  oscDivQ, oscCntQ;

  logic wrCtrl, wrPre, swRstReq, oscActive, oscDone, srcTick;

  assign wrCtrl   = wrEn && (addr == CTRL_A) && !clearQ;
  assign wrPre    = wrEn && (addr == PRE_A) && !clearQ;
  assign swRstReq = wrCtrl && wrData[SWR_BIT];

  assign oscActive = enQ && (srcQ == SRC_OSC) && oscEnQ;
  assign oscDone   = oscActive && oscTick && (oscCntQ >= oscDivQ);

  always_comb begin
    srcTick = 1'b0;
    if (enQ) begin
      unique case (srcQ)
        SRC_PER: srcTick = perTick;
        SRC_REF: srcTick = refTick;
        SRC_OSC: srcTick = oscDone;
        default: srcTick = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ      <= 1'b0;
      modeQ    <= 1'b0;
      oscEnQ   <= 1'b0;
      srcQ     <= '0;
      mainDivQ <= '0;
      oscDivQ  <= '0;
      oscCntQ  <= '0;
      clearQ   <= 1'b0;
    end else if (clearQ) begin
      enQ      <= 1'b0;
      modeQ    <= 1'b0;
      oscEnQ   <= 1'b0;
      srcQ     <= '0;
      mainDivQ <= '0;
      oscDivQ  <= '0;
      oscCntQ  <= '0;
      clearQ   <= 1'b0;
    end else begin
      clearQ <= swRstReq;
      if (wrCtrl && !wrData[SWR_BIT]) begin
        enQ    <= wrData[EN_BIT];
        srcQ   <= wrData[SRC_LSB +: 3];
        modeQ  <= wrData[MODE_BIT];
        oscEnQ <= wrData[OSC_EN_BIT];
      end
      if (wrPre) begin
        mainDivQ <= wrData[MAIN_DIV_W-1:0];
        oscDivQ  <= wrData[OSC_DIV_LSB +: OSC_DIV_W];
      end
      if (oscActive && oscTick)
        oscCntQ <= oscDone ? '0 : oscCntQ + 1'b1;
    end
  end

  assign strobe.tick  = srcTick && !clearQ;
  assign strobe.clear = clearQ;
  assign mainDiv      = mainDivQ;

  always_comb begin
    ctrlWord                   = '0;
    ctrlWord[EN_BIT]           = enQ;
    ctrlWord[SRC_LSB +: 3]     = srcQ;
    ctrlWord[MODE_BIT]         = modeQ;
    ctrlWord[OSC_EN_BIT]       = oscEnQ;
    preWord                            = '0;
    preWord[MAIN_DIV_W-1:0]            = mainDivQ;
    preWord[OSC_DIV_LSB +: OSC_DIV_W]  = oscDivQ;
  end

endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int MAIN_DIV_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tmrStrobe_t            strobe,
  input  logic [MAIN_DIV_W-1:0] mainDiv,
  output logic [CNT_W-1:0]      count
);

  logic [MAIN_DIV_W-1:0] mainCntQ;
  logic [CNT_W-1:0]      countQ;
  logic                  divDone;

  assign divDone = strobe.tick && (mainCntQ >= mainDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCntQ <= '0;
      countQ   <= '0;
    end else if (strobe.clear) begin
      mainCntQ <= '0;
      countQ   <= '0;
    end else if (strobe.tick) begin
      mainCntQ <= divDone ? '0 : mainCntQ + 1'b1;
      if (divDone)
        countQ <= countQ + 1'b1;
    end
  end

  assign count = countQ;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 32,
  parameter int MAIN_DIV_W = 12,
  parameter int OSC_DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              perTick,
  input  logic              refTick,
  input  logic              oscTick
);

  tmrStrobe_t            strobe;
  logic [MAIN_DIV_W-1:0] mainDiv;
  logic [31:0]           ctrlWord, preWord, countWord;
  logic [CNT_W-1:0]      count;
  logic                  clearPulse;

  tick_timer_ctrl #(
    .ADDR_W(ADDR_W), .MAIN_DIV_W(MAIN_DIV_W), .OSC_DIV_W(OSC_DIV_W)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .perTick(perTick), .refTick(refTick), .oscTick(oscTick),
    .strobe(strobe), .mainDiv(mainDiv), .ctrlWord(ctrlWord), .preWord(preWord)
  );

  tick_timer_dp #(
    .CNT_W(CNT_W), .MAIN_DIV_W(MAIN_DIV_W)
  ) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mainDiv(mainDiv), .count(count)
  );

  assign clearPulse = strobe.clear;

  generate
    if (CNT_W < 32) begin : gPad
      assign countWord = {{(32-CNT_W){1'b0}}, count};
    end else begin : gFull
      assign countWord = count[31:0];
    end
  endgenerate

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(CTRL_WORD): busRdData = ctrlWord;
      ADDR_W'(PRE_WORD):  busRdData = preWord;
      ADDR_W'(CNT_WORD):  busRdData = countWord;
      default:            busRdData = '0;
    endcase
  end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdData,
  input logic [31:0]       ctrlWord,
  input logic [31:0]       preWord,
  input logic [CNT_W-1:0]  count,
  input logic              clearPulse
);

  logic [2:0] srcSel;
  logic       badSel;
  assign srcSel = ctrlWord[8:6];
  assign badSel = (srcSel != 3'b001) && (srcSel != 3'b100) && (srcSel != 3'b101);

  a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWord[0] && !clearPulse) |=> $stable(count));

  a_r4_no_count_bad_source: assert property (@(posedge clk) disable iff (!rstN)
    (badSel && !clearPulse) |=> $stable(count));

  a_r5_osc_gated: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 3'b101 && !ctrlWord[10] && !clearPulse) |=> $stable(count));

  a_r8_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !clearPulse |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r10_clears_all: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> (count == '0 && ctrlWord == '0 && preWord == '0));

  a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    clearPulse |=> !clearPulse);

  a_r2_status_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(2)) |-> (busRdData == '0));

endmodule

bind tick_timer tick_timer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chkInst (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRdData(busRdData),
  .ctrlWord(ctrlWord), .preWord(preWord), .count(count), .clearPulse(clearPulse)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdData, rdNarrow;
  logic        perTick = 1'b0, refTick = 1'b0, oscTick = 1'b0;

  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tick_timer uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdData),
    .perTick(perTick), .refTick(refTick), .oscTick(oscTick)
  );

  tick_timer #(.CNT_W(8)) uutNarrow (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdNarrow),
    .perTick(perTick), .refTick(refTick), .oscTick(oscTick)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlVal(input bit en, input logic [2:0] src,
                                          input bit mode, input bit oscEn);
    return 32'(en) | (32'(src) << 6) | (32'(mode) << 9) | (32'(oscEn) << 10);
  endfunction

  function automatic int expCount(input logic [2:0] src, input bit oscEn,
                                  input int t, input int m, input int n);
    if (src == 3'b001 || src == 3'b100) return t / (n + 1);
    if (src == 3'b101 && oscEn) return t / ((m + 1) * (n + 1));
    return 0;
  endfunction

  // Called just after a falling edge; no clock edge passes.
  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic swReset();
    wr(4'd0, 32'h0000_8000);
    @(negedge clk);
  endtask

  task automatic drive(input int n, input logic [2:0] mask);
    for (int i = 0; i < n; i++) begin
      {oscTick, refTick, perTick} = mask;
      @(negedge clk);
    end
    {oscTick, refTick, perTick} = 3'b000;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0;
    int seedSink;
    seedSink = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, d); check("R1 ctrl", d, 0);
    rd(4'd1, d); check("R1 pre", d, 0);
    rd(4'd2, d); check("R1 status", d, 0);
    rd(4'd9, d); check("R1 count", d, 0);

    // R2 register map
    @(negedge clk);
    wr(4'd0, 32'hFFFF_7FFF); rd(4'd0, d); check("R2 ctrl bits", d, 32'h0000_07C1);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, d); check("R2 pre bits", d, 32'h0000_FFFF);
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, d); check("R2 status", d, 0);
    rd(4'd3, d); check("R2 unused word", d, 0);
    rd(4'd9, d); check("R4 bad source no count", d, 0);
    @(negedge clk);
    swReset();

    // R3 enable / freeze / resume
    wr(4'd1, 0);
    wr(4'd0, ctrlVal(1, 3'b001, 0, 0));
    drive(5, 3'b001); rd(4'd9, d); check("R3 count on", d, 5);
    @(negedge clk);
    wr(4'd0, ctrlVal(0, 3'b001, 0, 0));
    drive(5, 3'b001); rd(4'd9, d); check("R3 frozen", d, 5);
    @(negedge clk);
    wr(4'd0, ctrlVal(1, 3'b001, 0, 0));
    drive(3, 3'b001); rd(4'd9, d); check("R3 resumed", d, 8);
    @(negedge clk);

    // R11 timing of the update
    rd(4'd9, c0);
    perTick = 1'b1;
    #0;
    rd(4'd9, d); check("R11 before edge", d, c0);
    @(negedge clk); perTick = 1'b0;
    rd(4'd9, d); check("R11 after edge", d, c0 + 1);
    @(negedge clk);

    // R9 counter writes ignored, tick in the same cycle still counts
    rd(4'd9, c0);
    @(negedge clk);
    wr(4'd9, 32'h1234_5678); rd(4'd9, d); check("R9 write ignored", d, c0);
    @(negedge clk);
    perTick = 1'b1; wr(4'd9, 32'h0); perTick = 1'b0;
    rd(4'd9, d); check("R9 write with tick", d, c0 + 1);
    @(negedge clk);

    // R5 oscillator gate
    swReset();
    wr(4'd0, ctrlVal(1, 3'b101, 0, 0));
    drive(10, 3'b100); rd(4'd9, d); check("R5 gated", d, 0);
    @(negedge clk);
    wr(4'd0, ctrlVal(1, 3'b101, 0, 1));
    drive(10, 3'b100); rd(4'd9, d); check("R5 open", d, 10);
    @(negedge clk);

    // R6 / R7 dividers
    swReset();
    wr(4'd1, 32'd2); wr(4'd0, ctrlVal(1, 3'b001, 0, 0));
    drive(8, 3'b001); rd(4'd9, d); check("R6 main divide by 3", d, 2);
    @(negedge clk);
    swReset();
    wr(4'd1, 32'h0000_7000); wr(4'd0, ctrlVal(1, 3'b101, 0, 1));
    drive(24, 3'b100); rd(4'd9, d); check("R7 osc divide by 8", d, 3);
    @(negedge clk);
    swReset();
    wr(4'd1, 32'h0000_1002); wr(4'd0, ctrlVal(1, 3'b101, 0, 1));
    drive(11, 3'b100); rd(4'd9, d); check("R7 11 strobes by 6", d, 1);
    @(negedge clk);
    drive(1, 3'b100); rd(4'd9, d); check("R7 12 strobes by 6", d, 2);
    @(negedge clk);

    // R8 wrap on the narrow instance, restart mode
    swReset();
    wr(4'd1, 0); wr(4'd0, ctrlVal(1, 3'b001, 1, 0));
    drive(255, 3'b001);
    busAddr = 4'd9; #1;
    check("R8 narrow all ones", rdNarrow, 32'hFF);
    @(negedge clk);
    drive(1, 3'b001);
    busAddr = 4'd9; #1;
    check("R8 narrow wrapped", rdNarrow, 0);
    check("R8 wide no wrap", rdData, 32'h100);
    @(negedge clk);

    // R10 clear cycle collides with a tick
    swReset();
    wr(4'd1, 32'd0); wr(4'd0, ctrlVal(1, 3'b001, 0, 0));
    drive(3, 3'b001);
    perTick = 1'b1;
    wr(4'd0, 32'h0000_8000);
    rd(4'd0, d); check("R10 ctrl not written", d, ctrlVal(1, 3'b001, 0, 0));
    rd(4'd9, d); check("R10 tick in write cycle", d, 4);
    @(negedge clk);
    perTick = 1'b0;
    rd(4'd9, d); check("R10 count cleared", d, 0);
    rd(4'd0, d); check("R10 ctrl cleared", d, 0);
    rd(4'd1, d); check("R10 pre cleared", d, 0);
    @(negedge clk);

    // Random mix, all sources toggling, only the selected one counts
    for (int it = 0; it < 40; it++) begin
      logic [2:0] src;
      bit oscEn;
      int m, n, t, cycles;
      logic [2:0] pick;
      case ($urandom_range(0, 4))
        0: src = 3'b001;
        1: src = 3'b100;
        2: src = 3'b101;
        3: src = 3'b101;
        default: src = 3'($urandom_range(0, 7));
      endcase
      oscEn = ($urandom_range(0, 3) != 0);
      m = $urandom_range(0, 3);
      n = $urandom_range(0, 4);
      cycles = $urandom_range(0, 60);
      swReset();
      wr(4'd1, (32'(m) << 12) | 32'(n));
      wr(4'd0, ctrlVal(1, src, it[0], oscEn));
      t = 0;
      for (int c = 0; c < cycles; c++) begin
        pick = 3'($urandom_range(0, 7));
        {oscTick, refTick, perTick} = pick;
        if ((src == 3'b001 && pick[0]) || (src == 3'b100 && pick[1]) ||
            (src == 3'b101 && pick[2])) t++;
        @(negedge clk);
      end
      {oscTick, refTick, perTick} = 3'b000;
      rd(4'd9, d);
      check("R4 R6 R7 random", d, 32'(expCount(src, oscEn, t, m, n)));
      @(negedge clk);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule